// File: doc/BRIEF.md
# Predicated Status Flag Unit

This block owns the four processor status flags (carry, overflow, negative, zero). It decides whether the instruction now in execute may take effect, based on the 3-bit condition prefix that every instruction carries. The decision is made combinationally from the flags as they stand, so a predicated instruction that follows a flag-setting one sees the updated flags. When the condition holds and the instruction belongs to a flag-setting class, the block computes new flags from the operands, result and carry-out supplied by the ALU, and stores them at the next clock edge.

When the condition fails, the instruction is squashed. No flag update happens, and the commit and register-write enables stay low, so the register file and memory stay untouched. The program counter step is still reported, because a squashed instruction is skipped, not retried. That step comes from a per-major-opcode length table: each instruction occupies one or two 16-bit words. A separate restore path reloads the flags as one word on return from interrupt. It wins over any ALU update in the same cycle.

The reset input is asserted asynchronously and released through a two-stage synchronizer. The flag register therefore leaves its reset state on the second clock edge after reset is released.

Top module: `pred_flag_unit`

## Requirements
- R1: The flag output `flags_q` is packed as C in bit 3, V in bit 2, N in bit 1 and Z in bit 0. It reads 0 while reset is asserted, and it becomes 0 as soon as `rst_n` falls, without waiting for a clock edge.
- R2: `exec_en` is driven from `cond` and the current `flags_q`. The codes are: 0 always true; 1 true when Z=1; 2 true when Z=0; 3 true when C=1; 4 true when C=0; 5 true when N=1; 6 true when V=1; 7 true when N differs from V.
- R3: `op_class` 1 (add) with a committed instruction loads the flags on the next edge as follows: C equals `alu_cout`; V is set when both operands have the same sign and the result sign differs from it; N equals result bit 15; Z is set when the result is zero.
- R4: `op_class` 2 (subtract, a minus b) and 3 (compare) set the flags the same way. C is the borrow, set when `opnd_a` < `opnd_b` unsigned. V is set when the operand signs differ and the result sign differs from `opnd_a`. N and Z are set as for add.
- R5: `op_class` 4 (logical) updates only N and Z from the result, and keeps C and V at their previous values.
- R6: `alu_wr_en` is high for a committed add, subtract or logical instruction. It stays low for compare and for every other class.
- R7: When `op_valid` is high and the condition is false, `commit_en` and `alu_wr_en` are low and `flags_q` is unchanged at the next edge. `pc_step` still gives the instruction length.
- R8: When `restore_en` is high, `flags_q` takes `restore_flags` at the next edge. This happens whatever the condition, class or `op_valid`.
- R9: `pc_step` is 2 when the bit of `opc_major` in the parameter LONG_MASK is set, and 1 otherwise. By default, major opcodes 4, 5, 8 and 12 are two words long.
- R10: `op_class` 0 and the unused codes 5 to 7, or `op_valid` low, leave the flags unchanged and keep `alu_wr_en` low. With `op_valid` high and the condition true, `commit_en` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An instruction is in execute this cycle |
| op_class | input | 3 | Flag class: 0 none, 1 add, 2 sub, 3 compare, 4 logical |
| opnd_a | input | 16 | First ALU operand (destination register value) |
| opnd_b | input | 16 | Second ALU operand |
| alu_res | input | 16 | ALU result |
| alu_cout | input | 1 | ALU carry-out for add |
| cond | input | 3 | Condition prefix of the instruction |
| opc_major | input | 4 | Major opcode used for the length lookup |
| restore_en | input | 1 | Reload the flags from `restore_flags` |
| restore_flags | input | 4 | Flag word to reload, same packing as `flags_q` |
| flags_q | output | 4 | Current flags {C,V,N,Z} |
| exec_en | output | 1 | Condition prefix holds on the current flags |
| commit_en | output | 1 | Instruction takes effect (valid and condition true) |
| alu_wr_en | output | 1 | ALU result may be written to the register file |
| pc_step | output | 2 | Instruction length in words (1 or 2) |

## Verification
The hardest situation to reach is a restore that meets a committed, flag-setting instruction in the same cycle. The restore must win, and the stored flags must also be the ones used by the next predicated instruction. The stimulus reaches it by first driving the flags into a known pattern with arithmetic, then issuing a logical or subtract instruction with `restore_en` raised. A follow-up instruction whose condition depends only on the restored bits is sent next. Signed-overflow and borrow corners come from operand pairs at 0x7FFF, 0x8000 and 0xFFFF. Each of the eight conditions is swept over flag patterns loaded through the restore path.

// File: rtl/pfu_pkg.sv
package pfu_pkg;

  localparam int unsigned DATA_W   = 16;
  localparam int unsigned COND_W   = 3;
  localparam int unsigned N_COND   = 1 << COND_W;
  localparam int unsigned MAJOR_W  = 4;
  localparam int unsigned N_MAJOR  = 1 << MAJOR_W;
  localparam int unsigned FLAG_W   = 4;

  typedef enum logic [2:0] {
    CLS_NONE  = 3'd0,
    CLS_ADD   = 3'd1,
    CLS_SUB   = 3'd2,
    CLS_CMP   = 3'd3,
    CLS_LOGIC = 3'd4
  } op_class_e;

  typedef struct packed {
    logic c;
    logic v;
    logic n;
    logic z;
  } flags_t;

  // Truth of one condition code on a flag set.
  function automatic logic cond_holds(input logic [COND_W-1:0] code, input flags_t f);
    logic t;
    case (code)
      3'd0:    t = 1'b1;
      3'd1:    t = f.z;
      3'd2:    t = ~f.z;
      3'd3:    t = f.c;
      3'd4:    t = ~f.c;
      3'd5:    t = f.n;
      3'd6:    t = f.v;
      default: t = f.n ^ f.v;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/pfu_rst_sync.sv
module pfu_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/pfu_cond_eval.sv
module pfu_cond_eval
  import pfu_pkg::*;
(
  input  flags_t              flags,
  input  logic [COND_W-1:0]   cond,
  output logic                holds
);

  logic [N_COND-1:0] truth;

  for (genvar k = 0; k < N_COND; k++) begin : g_cond
    assign truth[k] = cond_holds(COND_W'(k), flags);
  end

  assign holds = truth[cond];

endmodule

// File: rtl/pfu_len_table.sv
module pfu_len_table
  import pfu_pkg::*;
#(
  parameter logic [N_MAJOR-1:0] LONG_MASK = 16'h1130
) (
  input  logic [MAJOR_W-1:0] major,
  output logic [1:0]         words
);

  logic [1:0] len_rom [N_MAJOR];

  for (genvar m = 0; m < N_MAJOR; m++) begin : g_len
    assign len_rom[m] = LONG_MASK[m] ? 2'd2 : 2'd1;
  end

  assign words = len_rom[major];

endmodule

// File: rtl/pfu_flag_calc.sv
module pfu_flag_calc
  import pfu_pkg::*;
(
  input  op_class_e          cls,
  input  logic [DATA_W-1:0]  a,
  input  logic [DATA_W-1:0]  b,
  input  logic [DATA_W-1:0]  res,
  input  logic               cout,
  input  flags_t             cur,
  output flags_t             nxt,
  output logic               touches,
  output logic               writes
);

  localparam int unsigned MSB = DATA_W - 1;

  logic   res_zero;
  logic   add_ovf;
  logic   sub_ovf;
  logic   borrow;

  assign res_zero = (res == '0);
  assign add_ovf  = (a[MSB] == b[MSB]) && (res[MSB] != a[MSB]);
  assign sub_ovf  = (a[MSB] != b[MSB]) && (res[MSB] != a[MSB]);
  assign borrow   = (a < b);

  always_comb begin
    nxt     = cur;
    touches = 1'b0;
    writes  = 1'b0;
    unique case (cls)
      CLS_ADD: begin
        nxt     = '{c: cout, v: add_ovf, n: res[MSB], z: res_zero};
        touches = 1'b1;
        writes  = 1'b1;
      end
      CLS_SUB, CLS_CMP: begin
        nxt     = '{c: borrow, v: sub_ovf, n: res[MSB], z: res_zero};
        touches = 1'b1;
        writes  = (cls == CLS_SUB);
      end
      CLS_LOGIC: begin
        nxt.n   = res[MSB];
        nxt.z   = res_zero;
        touches = 1'b1;
        writes  = 1'b1;
      end
      default: begin
        nxt     = cur;
      end
    endcase
  end

endmodule

// File: rtl/pfu_flag_reg.sv
module pfu_flag_reg
  import pfu_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   restore_en,
  input  flags_t restore_val,
  input  logic   upd_en,
  input  flags_t upd_val,
  output flags_t q
);

  flags_t d;
  logic   ld_en;

  always_comb begin
    ld_en = restore_en | upd_en;
    if (restore_en) d = restore_val;
    else            d = upd_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (ld_en) q <= d;
  end

endmodule

// File: rtl/pred_flag_unit.sv
module pred_flag_unit
  import pfu_pkg::*;
#(
  parameter logic [15:0] LONG_MASK  = 16'h1130,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic [2:0]  op_class,
  input  logic [15:0] opnd_a,
  input  logic [15:0] opnd_b,
  input  logic [15:0] alu_res,
  input  logic        alu_cout,
  input  logic [2:0]  cond,
  input  logic [3:0]  opc_major,
  input  logic        restore_en,
  input  logic [3:0]  restore_flags,
  output logic [3:0]  flags_q,
  output logic        exec_en,
  output logic        commit_en,
  output logic        alu_wr_en,
  output logic [1:0]  pc_step
);

  logic      rst_q_n;
  flags_t    cur_flags;
  flags_t    calc_flags;
  op_class_e cls;
  logic      cls_touches;
  logic      cls_writes;
  logic      cond_ok;
  logic      upd_en;

  assign cls = op_class_e'(op_class);

  pfu_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  pfu_cond_eval u_cond (
    .flags (cur_flags),
    .cond  (cond),
    .holds (cond_ok)
  );

  pfu_flag_calc u_calc (
    .cls     (cls),
    .a       (opnd_a),
    .b       (opnd_b),
    .res     (alu_res),
    .cout    (alu_cout),
    .cur     (cur_flags),
    .nxt     (calc_flags),
    .touches (cls_touches),
    .writes  (cls_writes)
  );

  pfu_len_table #(.LONG_MASK(LONG_MASK)) u_len (
    .major (opc_major),
    .words (pc_step)
  );

  assign commit_en = op_valid & cond_ok;
  assign upd_en    = commit_en & cls_touches;
  assign alu_wr_en = commit_en & cls_writes;
  assign exec_en   = cond_ok;

  pfu_flag_reg u_flags (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .restore_en  (restore_en),
    .restore_val (flags_t'(restore_flags)),
    .upd_en      (upd_en),
    .upd_val     (calc_flags),
    .q           (cur_flags)
  );

  assign flags_q = cur_flags;

endmodule

// File: rtl/pred_flag_unit_chk.sv
module pred_flag_unit_chk (
  input logic        clk,
  input logic        rst_q_n,
  input logic        op_valid,
  input logic [2:0]  op_class,
  input logic [2:0]  cond,
  input logic        restore_en,
  input logic [3:0]  restore_flags,
  input logic [3:0]  flags_q,
  input logic        exec_en,
  input logic        commit_en,
  input logic        alu_wr_en,
  input logic [1:0]  pc_step
);

  // R2: equality conditions follow Z
  assert_eq_follows_z_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cond == 3'd1) |-> (exec_en == flags_q[0]));

  // R2: less-than follows N xor V
  assert_lt_follows_nv_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cond == 3'd7) |-> (exec_en == (flags_q[1] ^ flags_q[2])));

  // R5: logical op keeps C and V
  assert_logic_keeps_cv_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (commit_en && op_class == 3'd4 && !restore_en) |=> (flags_q[3:2] == $past(flags_q[3:2])));

  // R6: compare never writes a register
  assert_cmp_no_write_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (op_class == 3'd3) |-> !alu_wr_en);

  // R7: squashed instruction leaves flags alone
  assert_squash_holds_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (op_valid && !exec_en && !restore_en) |=> $stable(flags_q));

  // R7: register write needs a committed instruction
  assert_write_needs_commit_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    alu_wr_en |-> (commit_en && exec_en && op_valid));

  // R8: restore wins
  assert_restore_wins_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    restore_en |=> (flags_q == $past(restore_flags)));

  // R9: length is one or two words
  always_comb begin
    if (rst_q_n) begin
      assert_len_range_R9: assert (pc_step == 2'd1 || pc_step == 2'd2);
    end
  end

  // R10: idle cycles leave flags alone
  assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!op_valid && !restore_en) |=> $stable(flags_q));

endmodule

bind pred_flag_unit pred_flag_unit_chk u_chk (
  .clk           (clk),
  .rst_q_n       (rst_q_n),
  .op_valid      (op_valid),
  .op_class      (op_class),
  .cond          (cond),
  .restore_en    (restore_en),
  .restore_flags (restore_flags),
  .flags_q       (flags_q),
  .exec_en       (exec_en),
  .commit_en     (commit_en),
  .alu_wr_en     (alu_wr_en),
  .pc_step       (pc_step)
);

// File: tb/pred_flag_unit_test.sv
`timescale 1ns/1ps
module pred_flag_unit_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [2:0]  op_class;
  logic [15:0] opnd_a, opnd_b, alu_res;
  logic        alu_cout;
  logic [2:0]  cond;
  logic [3:0]  opc_major;
  logic        restore_en;
  logic [3:0]  restore_flags;
  logic [3:0]  flags_q;
  logic        exec_en, commit_en, alu_wr_en;
  logic [1:0]  pc_step;

  int checks = 0;
  int fails  = 0;
  logic [3:0] model_f;

  typedef struct {
    logic [3:0] flags;
    string      req;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  pred_flag_unit uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_class(op_class),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .alu_res(alu_res), .alu_cout(alu_cout),
    .cond(cond), .opc_major(opc_major), .restore_en(restore_en),
    .restore_flags(restore_flags), .flags_q(flags_q), .exec_en(exec_en),
    .commit_en(commit_en), .alu_wr_en(alu_wr_en), .pc_step(pc_step)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic m_cond(input logic [2:0] c, input logic [3:0] f);
    case (c)
      0: return 1'b1;
      1: return f[0];
      2: return !f[0];
      3: return f[3];
      4: return !f[3];
      5: return f[1];
      6: return f[2];
      default: return f[1] != f[2];
    endcase
  endfunction

  // Monitor: compare stored flags one step after each driven cycle
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(e.req, flags_q, e.flags);
    end
  end

  task automatic issue(input logic v, input logic [2:0] cls,
                       input logic [15:0] a, input logic [15:0] b,
                       input logic [15:0] r, input logic co,
                       input logic [2:0] c, input logic [3:0] maj,
                       input logic re, input logic [3:0] rf, input string req);
    logic ok, ld, wr;
    logic [3:0] nf;
    exp_t e;
    @(negedge clk);
    op_valid = v; op_class = cls; opnd_a = a; opnd_b = b; alu_res = r;
    alu_cout = co; cond = c; opc_major = maj; restore_en = re; restore_flags = rf;
    #1;
    ok = m_cond(c, model_f);
    ld = v && ok;
    wr = ld && (cls == 1 || cls == 2 || cls == 4);
    nf = model_f;
    if (ld) begin
      case (cls)
        1: nf = {co, (a[15] == b[15]) && (r[15] != a[15]), r[15], r == 0};
        2, 3: nf = {a < b, (a[15] != b[15]) && (r[15] != a[15]), r[15], r == 0};
        4: nf = {model_f[3:2], r[15], r == 0};
        default: nf = model_f;
      endcase
    end
    if (re) nf = rf;
    check({req, " R2 exec_en"}, exec_en, ok);
    check({req, " R10 commit_en"}, commit_en, ld);
    check({req, " R6 alu_wr_en"}, alu_wr_en, wr);
    check({req, " R9 pc_step"}, pc_step, ((16'h1130 >> maj) & 1) ? 2 : 1);
    model_f = nf;
    e.flags = nf; e.req = {req, " flags"};
    sb.push_back(e);
  endtask

  task automatic idle_inputs();
    op_valid = 0; op_class = 0; opnd_a = 0; opnd_b = 0; alu_res = 0;
    alu_cout = 0; cond = 0; opc_major = 0; restore_en = 0; restore_flags = 0;
  endtask

  logic done = 1'b0;

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    model_f = 4'h0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1 reset flags", flags_q, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1 flags after release", flags_q, 0);

    // R3: add corners
    issue(1, 1, 16'h7FFF, 16'h0001, 16'h8000, 0, 0, 4'h1, 0, 0, "R3 add ovf");
    issue(1, 1, 16'hFFFF, 16'h0001, 16'h0000, 1, 0, 4'h1, 0, 0, "R3 add carry zero");
    issue(1, 1, 16'h0002, 16'h0003, 16'h0005, 0, 0, 4'h4, 0, 0, "R3 add plain");
    // R4: subtract and compare
    issue(1, 2, 16'h0003, 16'h0005, 16'hFFFE, 0, 0, 4'h1, 0, 0, "R4 sub borrow");
    issue(1, 3, 16'h8000, 16'h0001, 16'h7FFF, 0, 0, 4'h1, 0, 0, "R4 cmp ovf R6");
    issue(1, 3, 16'h1234, 16'h1234, 16'h0000, 0, 0, 4'h1, 0, 0, "R4 cmp equal");
    // R5: logical keeps C,V
    issue(1, 1, 16'h7FFF, 16'h0001, 16'h8000, 0, 0, 4'h1, 0, 0, "R3 set V");
    issue(1, 4, 16'h00F0, 16'h0F00, 16'h0000, 0, 0, 4'h1, 0, 0, "R5 logic zero");
    issue(1, 4, 16'hF000, 16'hFFFF, 16'hF000, 0, 0, 4'h1, 0, 0, "R5 logic neg");
    // R7: squash (Z=0 now, EQ fails)
    issue(1, 1, 16'h0000, 16'h0000, 16'h0000, 1, 1, 4'h5, 0, 0, "R7 squash eq");
    issue(1, 2, 16'h0001, 16'h0009, 16'hFFF8, 0, 3, 4'h8, 0, 0, "R7 squash cf");
    // R10: no-class and idle
    issue(1, 0, 16'h0000, 16'h0000, 16'h0000, 1, 0, 4'h0, 0, 0, "R10 class none");
    issue(1, 6, 16'h0000, 16'h0000, 16'h0000, 1, 0, 4'h0, 0, 0, "R10 class unused");
    issue(0, 1, 16'h0000, 16'h0000, 16'h0000, 1, 0, 4'h0, 0, 0, "R10 not valid");
    // R8: restore wins over committed update, then dependent condition
    issue(1, 2, 16'h0001, 16'h0002, 16'hFFFF, 0, 0, 4'h1, 1, 4'b0101, "R8 restore vs sub");
    issue(1, 4, 16'h0000, 16'h0000, 16'h0001, 0, 6, 4'h2, 1, 4'b1010, "R8 restore vs cond");
    issue(1, 4, 16'h0000, 16'h0000, 16'h0000, 0, 3, 4'h2, 0, 0, "R8 restored C used");
    // R2: sweep every condition over several flag patterns
    for (int p = 0; p < 16; p += 3) begin
      issue(0, 0, 0, 0, 0, 0, 0, 4'h0, 1, 4'(p), "R2 load pattern");
      for (int c = 0; c < 8; c++)
        issue(1, 0, 0, 0, 0, 0, 3'(c), 4'h0, 0, 0, "R2 sweep");
    end
    // R9: length table across all majors
    for (int m = 0; m < 16; m++)
      issue(0, 0, 0, 0, 0, 0, 0, 4'(m), 0, 0, "R9 length");
    @(negedge clk);
    idle_inputs();
    @(negedge clk);
    // R1: asynchronous clear
    issue(0, 0, 0, 0, 0, 0, 0, 4'h0, 1, 4'b1111, "R1 preload");
    @(negedge clk);
    #1;
    rst_n = 0;
    #1;
    check("R1 async clear", flags_q, 0);
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule